// File: doc/BRIEF.md
# Single-Cycle CRC-32 Custom-Instruction Unit

This block computes the 32-bit cyclic redundancy checksum used on Ethernet frames, built for a processor that calls it as a custom instruction. It holds a 32-bit running remainder. Each issued operation can fold one, two, three or four message bytes into that remainder within a single clock cycle. Division by the degree-32 generator over GF(2) is written as a fully unrolled XOR network, so no bit-serial shifting over several cycles takes place.

Software issues an operation by raising `start` for one cycle with a function code on `sel` and message data on `operand`. The finalised checksum shows up on `result` combinationally in the same cycle, and `done` is high for that cycle. The checksum is finalised by bit-reflecting the remainder and XORing it with a final constant. Each incoming byte is bit-reflected before it is folded in. These two steps give the usual least-significant-bit-first convention. A receiver can verify a frame by folding the frame followed by its own checksum. For every correct frame the result is a fixed residue.

Top module: `crc32_unit`

## Requirements
- R1: After reset the remainder holds the initial value 0xFFFFFFFF. A read operation (sel = 5) issued right after reset returns 0x00000000.
- R2: sel = 0 with start reloads the initial remainder. Its result in that cycle is 0x00000000.
- R3: sel = N (N = 1 to 4) with start folds the N low bytes of operand into the remainder in one cycle. Byte operand[7:0] is folded first, then operand[15:8], and so on upward. The result in that same cycle is the finalised checksum that includes those bytes.
- R4: In an update with sel = N, operand bytes above byte N-1 have no effect on the result or on the remainder.
- R5: sel = 5 returns the finalised checksum of the current remainder and leaves the remainder unchanged.
- R6: The checksum uses generator 0x04C11DB7, initial value 0xFFFFFFFF, reflected input bytes, reflected output and final XOR 0xFFFFFFFF. For the ASCII message "123456789" the checksum is 0xCBF43926, whatever the split into 1- to 4-byte operations.
- R7: While start is low the remainder does not change and done is low. done is high in exactly the cycles where start is high.
- R8: sel = 6 and sel = 7 return 0x00000000 and leave the remainder unchanged.
- R9: Folding any message followed by its four checksum bytes (least significant byte first) gives the result 0x2144DF1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation strobe; also enables the remainder register |
| sel | input | 3 | Function code: 0 init, 1-4 fold that many bytes, 5 read |
| operand | input | 32 | Message bytes, least significant byte consumed first |
| result | output | 32 | Finalised checksum for the selected function, combinational |
| done | output | 1 | High in the cycle an operation is issued |

## Verification
The assertions check four things on every cycle. The remainder holds its value when no strobe is present or when the code is read or unused. An init always leaves the initial value behind. The checksum reported by an update matches what a read in the following cycle returns. Only the bench's scenarios can show that the unrolled network computes the right CRC-32. They do this with an exhaustive single-byte sweep, the standard check string split several ways, a long pseudo-random mix of codes and strobes, and the receive-side residue. The same scenarios show that unused upper operand bytes really have no effect on the checksum.

// File: rtl/crc32_unit.sv
module crc32_unit #(
  parameter int          DW     = 32,
  parameter logic [31:0] POLY   = 32'h04C11DB7,
  parameter logic [31:0] INIT   = 32'hFFFFFFFF,
  parameter logic [31:0] XOROUT = 32'hFFFFFFFF,
  parameter bit          REFIN  = 1'b1,
  parameter bit          REFOUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    sel,
  input  logic [DW-1:0] operand,
  output logic [31:0]   result,
  output logic          done
);
  localparam int NB = DW / 8;
  localparam logic [2:0] OP_INIT = 3'd0;
  localparam logic [2:0] OP_READ = 3'd5;

  function automatic logic [7:0] rev8(input logic [7:0] b);
    for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
  endfunction

  function automatic logic [31:0] rev32(input logic [31:0] w);
    for (int i = 0; i < 32; i++) rev32[i] = w[31-i];
  endfunction

  function automatic logic [31:0] fold_byte(input logic [31:0] r, input logic [7:0] b);
    logic [31:0] t;
    t = r ^ {(REFIN ? rev8(b) : b), 24'h0};
    for (int k = 0; k < 8; k++)
      t = t[31] ? ((t << 1) ^ POLY) : (t << 1);
    return t;
  endfunction

  function automatic logic [31:0] finish(input logic [31:0] r);
    return (REFOUT ? rev32(r) : r) ^ XOROUT;
  endfunction

  logic [31:0] crc_q, crc_d;
  logic [31:0] stage [0:NB];

  assign stage[0] = crc_q;

  for (genvar g = 0; g < NB; g++) begin : g_fold
    assign stage[g+1] = fold_byte(stage[g], operand[8*g +: 8]);
  end

  always_comb begin
    crc_d  = crc_q;
    result = 32'h0;
    if (sel == OP_INIT) begin
      crc_d  = INIT;
      result = finish(INIT);
    end else if (sel == OP_READ) begin
      result = finish(crc_q);
    end
    for (int n = 1; n <= NB; n++) begin
      if (sel == 3'(n)) begin
        crc_d  = stage[n];
        result = finish(stage[n]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     crc_q <= INIT;
    else if (start) crc_q <= crc_d;
  end

  assign done = start;
endmodule

// File: rtl/crc32_unit_chk.sv
module crc32_unit_chk #(
  parameter logic [31:0] INIT = 32'hFFFFFFFF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [2:0]  sel,
  input logic [31:0] result,
  input logic [31:0] crc_q
);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(crc_q));

  // R2
  init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sel == 3'd0) |=> crc_q == INIT);

  // R5
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sel >= 3'd5) |=> $stable(crc_q));

  // R3
  update_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sel >= 3'd1 && sel <= 3'd4) |=>
      (!(start && sel == 3'd5) || result == $past(result)));
endmodule

bind crc32_unit crc32_unit_chk #(.INIT(INIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sel(sel),
  .result(result), .crc_q(crc_q)
);

// File: tb/sim_crc32_unit.sv
`timescale 1ns/1ps
module sim_crc32_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  sel = 3'd0;
  logic [31:0] operand = 32'h0;
  logic [31:0] result;
  logic        done;

  int checks = 0;
  int errors = 0;
  logic [31:0] mc;
  logic [31:0] got;
  logic        got_done;
  logic [31:0] lfsr = 32'h1D872B41;

  always #10 clk = ~clk;

  crc32_unit u0 (.clk(clk), .rst_n(rst_n), .start(start), .sel(sel),
                 .operand(operand), .result(result), .done(done));

  function automatic logic [31:0] m_fold(input logic [31:0] c, input logic [31:0] d, input int n);
    logic [31:0] t;
    t = c;
    for (int k = 0; k < n; k++) begin
      t = t ^ {24'h0, d[8*k +: 8]};
      for (int j = 0; j < 8; j++)
        t = t[0] ? ((t >> 1) ^ 32'hEDB88320) : (t >> 1);
    end
    return t;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic op(input logic st, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    start = st; sel = s; operand = d;
    #2;
    got = result; got_done = done;
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  function automatic logic [31:0] m_step(input logic st, input logic [2:0] s,
                                         input logic [31:0] d, inout logic [31:0] c);
    logic [31:0] nc, r;
    nc = c; r = 32'h0;
    if (s == 3'd0) begin nc = 32'hFFFFFFFF; r = 32'h0; end
    else if (s <= 3'd4) begin nc = m_fold(c, d, int'(s)); r = nc ^ 32'hFFFFFFFF; end
    else if (s == 3'd5) r = c ^ 32'hFFFFFFFF;
    if (st) c = nc;
    return r;
  endfunction

  task automatic run(input string req, input logic st, input logic [2:0] s, input logic [31:0] d);
    logic [31:0] e;
    e = m_step(st, s, d, mc);
    op(st, s, d);
    check(req, got, e);
  endtask

  function automatic logic [7:0] digit(input int i);
    return 8'h31 + 8'(i);
  endfunction

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mc = 32'hFFFFFFFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    run("R1", 1'b1, 3'd5, 32'h0);
    check("R1 reset read", got, 32'h00000000);
    check("R7 done", {31'h0, got_done}, 32'h1);

    // R6 check string byte by byte
    for (int i = 0; i < 9; i++) run("R3", 1'b1, 3'd1, {24'hA5C3E1, digit(i)});
    run("R6", 1'b1, 3'd5, 32'h0);
    check("R6 bytewise", got, 32'hCBF43926);

    // R2 init and R6 split 4+4+1
    run("R2", 1'b1, 3'd0, 32'hDEADBEEF);
    check("R2 init result", got, 32'h0);
    run("R3", 1'b1, 3'd4, 32'h34333231);
    run("R3", 1'b1, 3'd4, 32'h38373635);
    run("R4", 1'b1, 3'd1, 32'hFFFFFF39);
    check("R6 split 4/4/1", got, 32'hCBF43926);

    // R6 split 2+3+4 with junk above used bytes (R4)
    run("R2", 1'b1, 3'd0, 32'h0);
    run("R4", 1'b1, 3'd2, 32'h77883231);
    run("R4", 1'b1, 3'd3, 32'h99353433);
    run("R3", 1'b1, 3'd4, 32'h39383736);
    check("R6 split 2/3/4", got, 32'hCBF43926);

    // R5 read twice unchanged; R8 unused codes
    run("R5", 1'b1, 3'd5, 32'h0);
    check("R5 read", got, 32'hCBF43926);
    run("R8", 1'b1, 3'd6, 32'h12345678);
    check("R8 code6", got, 32'h0);
    run("R8", 1'b1, 3'd7, 32'h12345678);
    check("R8 code7", got, 32'h0);
    run("R5", 1'b1, 3'd5, 32'h0);
    check("R5 R8 unchanged", got, 32'hCBF43926);

    // R7 start low leaves state and done low
    run("R7", 1'b0, 3'd4, 32'h11223344);
    check("R7 done low", {31'h0, got_done}, 32'h0);
    run("R7", 1'b0, 3'd0, 32'h0);
    run("R7", 1'b1, 3'd5, 32'h0);
    check("R7 no change", got, 32'hCBF43926);

    // R3 R4 exhaustive single byte from init, junk above
    for (int b = 0; b < 256; b++) begin
      run("R2", 1'b1, 3'd0, 32'h0);
      run("R3 R4 byte sweep", 1'b1, 3'd1, {8'(b * 7), 8'(b ^ 8'h5A), 8'(~b), 8'(b)});
    end

    // R4 two-byte sweep of upper junk with fixed low bytes
    for (int j = 0; j < 256; j++) begin
      run("R2", 1'b1, 3'd0, 32'h0);
      run("R4 junk", 1'b1, 3'd2, {8'(j), 8'(j + 3), 16'hBEEF});
      check("R4 junk const", got, m_fold(32'hFFFFFFFF, 32'h0000BEEF, 2) ^ 32'hFFFFFFFF);
    end

    // R9 residue on two messages
    for (int m = 0; m < 2; m++) begin
      logic [31:0] ck;
      run("R2", 1'b1, 3'd0, 32'h0);
      run("R9", 1'b1, 3'd3, 32'h00ABCDEF ^ 32'(m * 32'h00010203));
      run("R9", 1'b1, 3'd4, 32'hCAFEF00D + 32'(m));
      ck = got;
      run("R9", 1'b1, 3'd4, ck);
      check("R9 residue", got, 32'h2144DF1C);
    end

    // R3 R5 R7 R8 pseudo-random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] e;
      logic st;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      st = lfsr[3] | lfsr[9];
      e = m_step(st, lfsr[6:4] == 3'd0 && lfsr[12] ? 3'd1 : lfsr[6:4], lfsr ^ 32'h9E3779B9, mc);
      op(st, lfsr[6:4] == 3'd0 && lfsr[12] ? 3'd1 : lfsr[6:4], lfsr ^ 32'h9E3779B9);
      check("R3 R5 R8 random", got, e);
      check("R7 done follows start", {31'h0, got_done}, {31'h0, st});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule